// File: doc/BRIEF.md
# Reset Cause Capture Controller

This block gathers every request that can reset the system and drives a single active-high system reset from them. The requests are power-on, supply-low trip, the external active-low reset pin, watchdog timeout, illegal opcode (a blocked STOP or HALT), an access to an illegal address, loss of the external clock, and low-leakage wakeup. Before a request can take part in a reset, it must pass its configuration gate. The external pin goes through a synchronizer and a glitch filter first.

For each reset event, the block stores which qualified sources caused it in a read-only cause register. Software reads that register once reset is released. The reset output stays asserted for a fixed stretch after the last request drops. The cause bits then stay unchanged until the next reset event begins.

Top module: `rst_cause_ctrl`

## Requirements
- R1: The system reset output `sys_reset` is 1 in the same cycle as any qualified request. It is 0 when no request is present and the hold stretch has expired.
- R2: `por_req` asserts `sys_reset` combinationally, without waiting for a clock. It records both the power-on bit (bit 7) and the supply-low bit (bit 1).
- R3: `pin_rst_n` passes through a two-flop synchronizer and counts only after two consecutive low samples. After the pin falls, `sys_reset` is first seen high in the cycle following the third rising edge. A pin that is low for one cycle only causes no reset. A valid pin reset sets bit 6.
- R4: `wdog_timeout` causes a reset and sets bit 5 only when `wdog_sel` is nonzero. When `wdog_sel` is 00 the timeout is ignored.
- R5: An illegal opcode sets bit 9 in two cases: `exec_stop` with both `stop_en` and `wait_en` at 0, or `exec_halt` with `dbg_en` at 0. In every other case the strobe is ignored.
- R6: `clk_lost` causes a reset and sets bit 2 only when `clk_mon_en` is 1.
- R7: `lvd_trip` causes a reset and sets bit 1 only when `lvd_rst_en` is 1.
- R8: After the last qualified request drops, `sys_reset` stays high for exactly 16 more cycles.
- R9: The first request cycle of a new event clears the cause register and loads only that cycle's sources. Any further source that appears while reset is still asserted is added to the register.
- R10: The cause register changes only while reset is asserted. Its unused positions (3, 4, 8, 11 to 15) always read 0.
- R11: `illegal_addr` sets bit 10 and `wakeup_req` sets bit 0. Neither needs a configuration gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low initialisation of the controller |
| por_req | input | 1 | Power-on request |
| lvd_trip | input | 1 | Supply below trip level |
| lvd_rst_en | input | 1 | Supply-low reset enable |
| pin_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_timeout | input | 1 | Watchdog expiry strobe |
| wdog_sel | input | 2 | Watchdog timeout select; 00 blocks the source |
| exec_stop | input | 1 | STOP executed strobe |
| stop_en | input | 1 | Stop mode enable |
| wait_en | input | 1 | Wait mode enable |
| exec_halt | input | 1 | HALT executed strobe |
| dbg_en | input | 1 | Debug interface enable |
| illegal_addr | input | 1 | Illegal address access strobe |
| clk_lost | input | 1 | External clock lost strobe |
| clk_mon_en | input | 1 | Clock monitor enable |
| wakeup_req | input | 1 | Low-leakage wakeup request |
| sys_reset | output | 1 | System reset, active high |
| cause | output | 16 | Latched reset cause bits |

## Verification
The hardest case to create is a second source that arrives while the hold stretch from an earlier request is still running. The register must merge that source into the current event instead of starting a new one. To reach it, the stimulus fires a qualified watchdog timeout and then raises an illegal address strobe two cycles later, well inside the 16-cycle hold. The stimulus then fires a lone wakeup to show that a fresh event clears both bits. Pin glitches are handled by sweeping the low time from one to four cycles and recording the cycle in which reset first appears.

// File: rtl/rcc_pkg.sv
// Shared constants for the reset cause controller: the layout of the
// cause register and the type that carries it. Assumes a 16-bit register.
package rcc_pkg;
    localparam int STATUS_W = 16;
    localparam int BIT_WAKE = 0;
    localparam int BIT_LVD  = 1;
    localparam int BIT_LOC  = 2;
    localparam int BIT_WDOG = 5;
    localparam int BIT_PIN  = 6;
    localparam int BIT_POR  = 7;
    localparam int BIT_ILOP = 9;
    localparam int BIT_ILAD = 10;
    typedef logic [STATUS_W-1:0] status_t;
endpackage

// File: rtl/rcc_pin_filter.sv
// External pin conditioner. Synchronizes the asynchronous active-low pin
// through SYNC_STAGES flops, then raises pin_req only when the last
// FILTER_LEN synchronized samples are all low. Assumes SYNC_STAGES >= 1 and
// FILTER_LEN >= 2.
module rcc_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_LEN  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_req
);
    localparam int CHAIN = SYNC_STAGES + FILTER_LEN - 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the pin level into the synchronizer and history chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[CHAIN-2:0], pin_n};
    end

    // A request needs the oldest FILTER_LEN samples to be low together.
    always_comb pin_req = ~|chain_q[CHAIN-1 -: FILTER_LEN];
endmodule

// File: rtl/rcc_qualify.sv
// Request qualifier. Gates each raw strobe with its configuration
// condition and places the result at its cause bit position. Power-on
// also drives the supply-low position. Purely combinational.
module rcc_qualify
    import rcc_pkg::*;
(
    input  logic       por_req,
    input  logic       lvd_trip,
    input  logic       lvd_rst_en,
    input  logic       pin_req,
    input  logic       wdog_timeout,
    input  logic [1:0] wdog_sel,
    input  logic       exec_stop,
    input  logic       stop_en,
    input  logic       wait_en,
    input  logic       exec_halt,
    input  logic       dbg_en,
    input  logic       illegal_addr,
    input  logic       clk_lost,
    input  logic       clk_mon_en,
    input  logic       wakeup_req,
    output status_t    req_vec
);
    // Build the qualified request vector in cause register layout.
    always_comb begin
        req_vec           = '0;
        req_vec[BIT_WAKE] = wakeup_req;
        req_vec[BIT_LVD]  = (lvd_trip & lvd_rst_en) | por_req;
        req_vec[BIT_LOC]  = clk_lost & clk_mon_en;
        req_vec[BIT_WDOG] = wdog_timeout & (wdog_sel != 2'b00);
        req_vec[BIT_PIN]  = pin_req;
        req_vec[BIT_POR]  = por_req;
        req_vec[BIT_ILOP] = (exec_stop & ~stop_en & ~wait_en) | (exec_halt & ~dbg_en);
        req_vec[BIT_ILAD] = illegal_addr;
    end
endmodule

// File: rtl/rcc_stretch.sv
// Reset hold counter. Loads HOLD while any request is present and counts
// down to zero afterwards. busy is high while the count is nonzero.
module rcc_stretch #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_any,
    output logic busy
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] cnt_q;

    // Reload on a request, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (req_any)        cnt_q <= CNT_W'(HOLD);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    // The hold is active while the count remains.
    always_comb busy = (cnt_q != '0);

    assert_hold_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_any |=> (cnt_q == CNT_W'(HOLD)));

    assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_any && busy) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rst_cause_ctrl.sv
// Reset cause controller top. Merges the qualified requests into
// sys_reset, holds reset with the stretch counter, and captures the
// cause bits per reset event. Power-on reaches sys_reset without a clock.
// Assumes rst_n initialises the controller itself once at start-up.
module rst_cause_ctrl
    import rcc_pkg::*;
#(
    parameter int HOLD        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILTER_LEN  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                por_req,
    input  logic                lvd_trip,
    input  logic                lvd_rst_en,
    input  logic                pin_rst_n,
    input  logic                wdog_timeout,
    input  logic [1:0]          wdog_sel,
    input  logic                exec_stop,
    input  logic                stop_en,
    input  logic                wait_en,
    input  logic                exec_halt,
    input  logic                dbg_en,
    input  logic                illegal_addr,
    input  logic                clk_lost,
    input  logic                clk_mon_en,
    input  logic                wakeup_req,
    output logic                sys_reset,
    output logic [STATUS_W-1:0] cause
);
    logic    pin_req;
    logic    req_any;
    logic    busy;
    status_t req_vec;
    status_t cause_q;

    rcc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .FILTER_LEN(FILTER_LEN)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin_n(pin_rst_n), .pin_req(pin_req)
    );

    rcc_qualify u_qual (
        .por_req(por_req), .lvd_trip(lvd_trip), .lvd_rst_en(lvd_rst_en),
        .pin_req(pin_req), .wdog_timeout(wdog_timeout), .wdog_sel(wdog_sel),
        .exec_stop(exec_stop), .stop_en(stop_en), .wait_en(wait_en),
        .exec_halt(exec_halt), .dbg_en(dbg_en), .illegal_addr(illegal_addr),
        .clk_lost(clk_lost), .clk_mon_en(clk_mon_en), .wakeup_req(wakeup_req),
        .req_vec(req_vec)
    );

    rcc_stretch #(.HOLD(HOLD)) u_hold (
        .clk(clk), .rst_n(rst_n), .req_any(req_any), .busy(busy)
    );

    // Any qualified request, power-on included, drives reset at once.
    always_comb req_any   = |req_vec;
    always_comb sys_reset = req_any | busy;

    // A new event replaces the causes; later sources in the same event add on.
    always_ff @(posedge clk) begin
        if (!rst_n)       cause_q <= '0;
        else if (req_any) cause_q <= busy ? (cause_q | req_vec) : req_vec;
    end

    always_comb cause = cause_q;

    assert_por_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |=> (cause[BIT_POR] && cause[BIT_LVD]));

    assert_por_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |-> sys_reset);

    assert_wdog_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wdog_sel == 2'b00) |-> !req_vec[BIT_WDOG]);

    assert_ilop_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_halt && (stop_en || wait_en)) |-> !req_vec[BIT_ILOP]);

    assert_cause_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_reset |=> $stable(cause));
endmodule

// File: tb/rst_cause_ctrl_test.sv
module rst_cause_ctrl_test;
    localparam logic [15:0] USED = 16'h06E7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_req, lvd_trip, lvd_rst_en, pin_rst_n, wdog_timeout;
    logic [1:0] wdog_sel;
    logic exec_stop, stop_en, wait_en, exec_halt, dbg_en;
    logic illegal_addr, clk_lost, clk_mon_en, wakeup_req;
    logic sys_reset;
    logic [15:0] cause;
    logic [15:0] exp_cause;
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rst_cause_ctrl uut (
        .clk(clk), .rst_n(rst_n), .por_req(por_req), .lvd_trip(lvd_trip),
        .lvd_rst_en(lvd_rst_en), .pin_rst_n(pin_rst_n), .wdog_timeout(wdog_timeout),
        .wdog_sel(wdog_sel), .exec_stop(exec_stop), .stop_en(stop_en), .wait_en(wait_en),
        .exec_halt(exec_halt), .dbg_en(dbg_en), .illegal_addr(illegal_addr),
        .clk_lost(clk_lost), .clk_mon_en(clk_mon_en), .wakeup_req(wakeup_req),
        .sys_reset(sys_reset), .cause(cause)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        por_req = 0; lvd_trip = 0; lvd_rst_en = 0; pin_rst_n = 1; wdog_timeout = 0;
        wdog_sel = 2'b00; exec_stop = 0; stop_en = 1; wait_en = 1; exec_halt = 0;
        dbg_en = 1; illegal_addr = 0; clk_lost = 0; clk_mon_en = 0; wakeup_req = 0;
    endtask

    // Raise source src with configuration cfg.
    task automatic drive_src(input int src, input int cfg);
        case (src)
            0: wakeup_req = 1;
            1: begin lvd_trip = 1; lvd_rst_en = cfg[0]; end
            2: begin clk_lost = 1; clk_mon_en = cfg[0]; end
            3: begin wdog_timeout = 1; wdog_sel = cfg[1:0]; end
            4: begin exec_stop = 1; stop_en = cfg[0]; wait_en = cfg[1]; end
            5: begin exec_halt = 1; dbg_en = cfg[0]; end
            6: illegal_addr = 1;
            default: por_req = 1;
        endcase
    endtask

    function automatic logic [15:0] exp_bits(input int src, input int cfg);
        logic [15:0] e = '0;
        case (src)
            0: e[0] = 1'b1;
            1: e[1] = cfg[0];
            2: e[2] = cfg[0];
            3: e[5] = (cfg[1:0] != 2'b00);
            4: e[9] = (cfg[1:0] == 2'b00);
            5: e[9] = !cfg[0];
            6: e[10] = 1'b1;
            default: begin e[7] = 1'b1; e[1] = 1'b1; end
        endcase
        return e;
    endfunction

    function automatic string src_tag(input int src);
        case (src)
            0: return "R11 wakeup";
            1: return "R7 lvd";
            2: return "R6 loc";
            3: return "R4 wdog";
            4: return "R5 stop";
            5: return "R5 halt";
            6: return "R11 ilad";
            default: return "R2 por";
        endcase
    endfunction

    // Count sys_reset cycles from the current sample point.
    task automatic count_hold(output int n);
        n = 0;
        while (sys_reset && n < 100) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic run_single(input int src, input int cfg);
        logic [15:0] e;
        int n;
        e = exp_bits(src, cfg);
        @(negedge clk); idle_inputs(); drive_src(src, cfg); #1;
        chk({src_tag(src), " R1 reset now"}, sys_reset, e != 0);
        @(negedge clk); idle_inputs(); #1;
        count_hold(n);
        chk({src_tag(src), " R8 hold"}, n, (e != 0) ? 16 : 0);
        if (e != 0) exp_cause = e;
        chk(src_tag(src), cause, exp_cause);
        chk("R10 unused zero", cause & ~USED, 0);
        repeat (3) @(negedge clk);
        #1 chk("R10 stable idle", cause, exp_cause);
    endtask

    initial begin
        int n;
        int first;
        idle_inputs();
        exp_cause = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 reset cause", cause, 0);
        chk("R1 reset idle", sys_reset, 0);

        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 4; c++)
                run_single(s, c);

        // R9: second source inside the hold merges into the same event.
        @(negedge clk); idle_inputs(); wdog_timeout = 1; wdog_sel = 2'b10;
        @(negedge clk); idle_inputs();
        @(negedge clk); illegal_addr = 1;
        @(negedge clk); idle_inputs(); #1;
        count_hold(n);
        chk("R9 merge hold", n, 16);
        chk("R9 merged causes", cause, 16'h0420);
        exp_cause = 16'h0420;
        run_single(0, 0);
        chk("R9 new event clears", cause, 16'h0001);

        // R3: pin low for 1..4 cycles.
        for (int len = 1; len <= 4; len++) begin
            first = 0;
            @(negedge clk); idle_inputs(); pin_rst_n = 0;
            for (int k = 1; k <= 30; k++) begin
                @(negedge clk);
                if (k == len) pin_rst_n = 1;
                #1;
                if (sys_reset && first == 0) first = k;
            end
            chk("R3 first reset cycle", first, (len >= 2) ? 3 : 0);
            if (len >= 2) exp_cause = 16'h0040;
            chk("R3 pin cause", cause, exp_cause);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule